// File: doc/BRIEF.md
# Tuning Synthesizer Reference Divider and Phase Detector

This block is the digital core of a radio tuning synthesizer. A reference divider counts crystal clocks and emits one tick per period of a selectable reference frequency. A programmable divide-by-N counter counts rising edges of the local-oscillator input and emits one tick every N edges. The oscillator input is sampled into the crystal clock domain, so it must toggle more slowly than half the crystal rate; any prescaling happens outside the block.

A two-flop phase/frequency detector compares the two tick streams. It drives a three-state main charge-pump code made of drive-high, drive-low and enable. Enable low means the pump driver is off (high impedance). A pulse-width monitor turns the pump activity into a lock flag. A sub-pump output copies the main pump either always, never, or only while the loop is out of lock. This lets an external fast-lock pump give extra current during acquisition.

Software or a sequencer sets the divide ratio, the reference code and the sub-pump mode. The `stop` input parks the whole loop with its pump drivers off.

Top module: `tune_pll_core`

## Requirements
- R1: `ref_sel` picks the reference tick period in crystal clocks as XTAL_HZ divided by the reference frequency. Codes 0 to 11 stand, in ascending order, for 1, 3, 3.125, 5, 6.25, 9, 10, 12.5, 25, 30, 50 and 100 kHz. Codes 12 to 15 behave as code 11. With the default 4.5 MHz crystal, code 11 gives 45 clocks, code 10 gives 90, code 9 gives 150 and code 0 gives 4500.
- R2: The divided oscillator tick occurs on every N-th sampled rising edge of `osc_in`. An `n_val` of 0 acts exactly like an `n_val` of 1.
- R3: When the divided tick arrives ahead of the reference tick, `pump_hi` is raised; when it lags, `pump_lo` is raised. The two are never high together, and `pump_lo` never directly follows a cycle with `pump_hi` high.
- R4: A divided tick and a reference tick in the same clock cycle produce no drive. When the two streams are frequency- and phase-aligned, `pump_en` stays low (pump off). A phase offset of k clocks gives a pump pulse k cycles wide.
- R5: While `stop` is high, all pump, sub-pump and lock outputs go low on the next clock and stay low. Both dividers restart from zero when `stop` is released.
- R6: While `rst` is high, all outputs are low, whatever the other inputs are doing.
- R7: A reference cycle in which the pump stays active for more than UNLOCK_CLKS (default 8) consecutive clocks is dirty. A pulse of exactly 8 clocks is clean and one of 9 is dirty. `locked` drops at the reference tick that closes a dirty cycle.
- R8: `locked` rises at the LOCK_CYCLES-th (default 4th) consecutive clean reference tick after a restart. It is visible on the clock edge of that tick.
- R9: A new `n_val` is taken up only at the next terminal count of the divide-by-N counter. The count already in progress ends with the old ratio.
- R10: `sub_mode` 2'b00 keeps the sub-pump off. 2'b11 makes `sub_hi`, `sub_lo` and `sub_en` equal `pump_hi`, `pump_lo` and `pump_en` in every cycle.
- R11: `sub_mode` 2'b01 and 2'b10 copy the main pump to the sub-pump only while `locked` is low, and keep it off while `locked` is high. `sub_fast` is high only in mode 2'b10, where it selects the faster external sub-pump setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Parks the loop with pumps off and counters cleared |
| osc_in | input | 1 | Local-oscillator input, sampled into the clock domain |
| n_val | input | N_W | Divide ratio for the oscillator counter, double buffered |
| ref_sel | input | 4 | Reference frequency code |
| sub_mode | input | 2 | Sub-pump behaviour select |
| pump_hi | output | 1 | Main pump drive-high |
| pump_lo | output | 1 | Main pump drive-low |
| pump_en | output | 1 | Main pump driver enable; low means high impedance |
| sub_hi | output | 1 | Sub-pump drive-high |
| sub_lo | output | 1 | Sub-pump drive-low |
| sub_en | output | 1 | Sub-pump driver enable |
| sub_fast | output | 1 | Faster sub-pump rate select |
| locked | output | 1 | Loop lock flag |

## Verification
The hardest case to reach from the ports is exact coincidence of the two tick streams. It depends on the synchronizer latency, which the bench does not assume. The bench sweeps the start delay of the oscillator waveform across all 45 phases of a 45-clock reference. It requires exactly one phase to give no pump activity at all, and reuses that phase as the zero-offset point. Adding 1, 8 or 9 clocks to that phase then places single-width, boundary-width and just-too-wide pulses on demand. The bench exercises the lock count, the unlock threshold and the deferred ratio change with those pulses.

// File: rtl/tpll_pkg.sv
package tpll_pkg;
  localparam int NUM_REFS = 12;
  localparam int SEL_W    = $clog2(NUM_REFS);

  typedef enum logic [1:0] {
    SUB_OFF       = 2'b00,
    SUB_UNLK_SLOW = 2'b01,
    SUB_UNLK_FAST = 2'b10,
    SUB_FOLLOW    = 2'b11
  } sub_mode_e;

  // Reference frequency in Hz for each select code; unused codes clamp to the highest.
  function automatic int unsigned ref_hz(input int unsigned code);
    case (code)
      0:       return 1000;
      1:       return 3000;
      2:       return 3125;
      3:       return 5000;
      4:       return 6250;
      5:       return 9000;
      6:       return 10000;
      7:       return 12500;
      8:       return 25000;
      9:       return 30000;
      10:      return 50000;
      default: return 100000;
    endcase
  endfunction
endpackage

// File: rtl/tpll_ref_div.sv
module tpll_ref_div
  import tpll_pkg::*;
#(
  parameter int XTAL_HZ = 4_500_000,
  localparam int REF_W  = $clog2(XTAL_HZ / 1000 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic [SEL_W-1:0] sel,
  output logic             ref_tick
);
  logic [REF_W-1:0] lim_tab [2**SEL_W];
  logic [REF_W-1:0] cnt;

  for (genvar g = 0; g < 2**SEL_W; g++) begin : g_tab
    assign lim_tab[g] = REF_W'(XTAL_HZ / ref_hz(g) - 1);
  end

  // Greater-or-equal so a shorter period chosen mid-count ends at once.
  assign ref_tick = !stop && (cnt >= lim_tab[sel]);

  always_ff @(posedge clk) begin
    if (rst || stop || ref_tick) cnt <= '0;
    else                         cnt <= cnt + REF_W'(1);
  end
endmodule

// File: rtl/tpll_n_div.sv
module tpll_n_div #(
  parameter int N_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stop,
  input  logic           osc_in,
  input  logic [N_W-1:0] n_val,
  output logic           div_tick
);
  logic [2:0]     smp;
  logic [N_W-1:0] cnt, n_act, n_eff;
  logic           rise;

  assign rise     = smp[1] && !smp[2];
  assign n_eff    = (n_val == '0) ? N_W'(1) : n_val;
  assign div_tick = !stop && rise && (cnt == n_act - N_W'(1));

  always_ff @(posedge clk) begin
    if (rst) smp <= '0;
    else     smp <= {smp[1:0], osc_in};
  end

  // Ratio shadow: reloaded only while parked or at terminal count.
  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt   <= '0;
      n_act <= n_eff;
    end else if (div_tick) begin
      cnt   <= '0;
      n_act <= n_eff;
    end else if (rise) begin
      cnt   <= cnt + N_W'(1);
    end
  end
endmodule

// File: rtl/tpll_pfd.sv
module tpll_pfd
  import tpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop,
  input  logic       ref_tick,
  input  logic       div_tick,
  input  logic       locked,
  input  logic [1:0] sub_mode,
  output logic       pump_hi,
  output logic       pump_lo,
  output logic       pump_en,
  output logic       sub_hi,
  output logic       sub_lo,
  output logic       sub_en,
  output logic       sub_fast
);
  sub_mode_e mode;
  logic      hi_set, lo_set, hi_d, lo_d, sub_on;

  assign mode = sub_mode_e'(sub_mode);

  always_comb begin
    hi_set = pump_hi || div_tick;
    lo_set = pump_lo || ref_tick;
    // Both flops set: clear both, so coincident ticks give no drive.
    hi_d   = hi_set && !lo_set;
    lo_d   = lo_set && !hi_set;
    case (mode)
      SUB_FOLLOW:                   sub_on = 1'b1;
      SUB_UNLK_SLOW, SUB_UNLK_FAST: sub_on = !locked;
      default:                      sub_on = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      pump_hi  <= 1'b0;
      pump_lo  <= 1'b0;
      pump_en  <= 1'b0;
      sub_hi   <= 1'b0;
      sub_lo   <= 1'b0;
      sub_en   <= 1'b0;
      sub_fast <= 1'b0;
    end else begin
      pump_hi  <= hi_d;
      pump_lo  <= lo_d;
      pump_en  <= hi_d || lo_d;
      sub_hi   <= hi_d && sub_on;
      sub_lo   <= lo_d && sub_on;
      sub_en   <= (hi_d || lo_d) && sub_on;
      sub_fast <= (mode == SUB_UNLK_FAST);
    end
  end
endmodule

// File: rtl/tpll_lock_det.sv
module tpll_lock_det #(
  parameter int UNLOCK_CLKS = 8,
  parameter int LOCK_CYCLES = 4,
  localparam int WID_W = $clog2(UNLOCK_CLKS + 1),
  localparam int CLN_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic pump_act,
  input  logic ref_tick,
  output logic locked
);
  logic [WID_W-1:0] wid;
  logic [CLN_W-1:0] clean;
  logic             dirty, wide;

  // Active now, after UNLOCK_CLKS active cycles already seen: pulse too wide.
  assign wide = pump_act && (wid == WID_W'(UNLOCK_CLKS));

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      wid    <= '0;
      dirty  <= 1'b0;
      clean  <= '0;
      locked <= 1'b0;
    end else begin
      if (!pump_act)                      wid <= '0;
      else if (wid != WID_W'(UNLOCK_CLKS)) wid <= wid + WID_W'(1);

      if (ref_tick) begin
        dirty <= 1'b0;
        if (dirty || wide) begin
          clean  <= '0;
          locked <= 1'b0;
        end else if (clean != CLN_W'(LOCK_CYCLES)) begin
          clean  <= clean + CLN_W'(1);
          locked <= (clean + CLN_W'(1) == CLN_W'(LOCK_CYCLES));
        end
      end else if (wide) begin
        dirty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tune_pll_core.sv
module tune_pll_core #(
  parameter int XTAL_HZ     = 4_500_000,
  parameter int N_W         = 16,
  parameter int UNLOCK_CLKS = 8,
  parameter int LOCK_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stop,
  input  logic           osc_in,
  input  logic [N_W-1:0] n_val,
  input  logic [3:0]     ref_sel,
  input  logic [1:0]     sub_mode,
  output logic           pump_hi,
  output logic           pump_lo,
  output logic           pump_en,
  output logic           sub_hi,
  output logic           sub_lo,
  output logic           sub_en,
  output logic           sub_fast,
  output logic           locked
);
  logic ref_tick, div_tick;

  tpll_ref_div #(.XTAL_HZ(XTAL_HZ)) u_ref (
    .clk(clk), .rst(rst), .stop(stop), .sel(ref_sel), .ref_tick(ref_tick)
  );

  tpll_n_div #(.N_W(N_W)) u_ndiv (
    .clk(clk), .rst(rst), .stop(stop), .osc_in(osc_in), .n_val(n_val),
    .div_tick(div_tick)
  );

  tpll_pfd u_pfd (
    .clk(clk), .rst(rst), .stop(stop), .ref_tick(ref_tick), .div_tick(div_tick),
    .locked(locked), .sub_mode(sub_mode),
    .pump_hi(pump_hi), .pump_lo(pump_lo), .pump_en(pump_en),
    .sub_hi(sub_hi), .sub_lo(sub_lo), .sub_en(sub_en), .sub_fast(sub_fast)
  );

  tpll_lock_det #(.UNLOCK_CLKS(UNLOCK_CLKS), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .stop(stop), .pump_act(pump_en), .ref_tick(ref_tick),
    .locked(locked)
  );
endmodule

// File: rtl/tune_pll_core_chk.sv
module tune_pll_core_chk #(
  parameter int UNLOCK_CLKS = 8,
  localparam int RUN_W = $clog2(UNLOCK_CLKS + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       stop,
  input logic [1:0] sub_mode,
  input logic       pump_hi,
  input logic       pump_lo,
  input logic       pump_en,
  input logic       sub_hi,
  input logic       sub_lo,
  input logic       sub_en,
  input logic       locked
);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !pump_en)                         run_len <= '0;
    else if (run_len != RUN_W'(UNLOCK_CLKS + 1)) run_len <= run_len + RUN_W'(1);
  end

  assert_pump_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(pump_hi && pump_lo));

  assert_no_hi_to_lo_R3: assert property (@(posedge clk) disable iff (rst)
    pump_hi |=> !pump_lo);

  assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!pump_en && !pump_hi && !pump_lo && !sub_en && !locked));

  assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pump_en && !sub_en && !locked));

  assert_lock_clean_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (run_len <= RUN_W'(UNLOCK_CLKS)));

  assert_sub_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> (sub_hi == pump_hi && sub_lo == pump_lo));

  assert_sub_gate_R11: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> ($past(sub_mode) == 2'b11 ||
                ($past(sub_mode) != 2'b00 && !$past(locked))));
endmodule

bind tune_pll_core tune_pll_core_chk #(.UNLOCK_CLKS(UNLOCK_CLKS)) u_chk (
  .clk(clk), .rst(rst), .stop(stop), .sub_mode(sub_mode),
  .pump_hi(pump_hi), .pump_lo(pump_lo), .pump_en(pump_en),
  .sub_hi(sub_hi), .sub_lo(sub_lo), .sub_en(sub_en), .locked(locked)
);

// File: tb/tune_pll_core_bench.sv
module tune_pll_core_bench;
  logic        clk = 1'b0, rst = 1'b1, stop = 1'b0, osc = 1'b0;
  logic [15:0] n_val = 16'd4;
  logic [3:0]  ref_sel = 4'd11;
  logic [1:0]  sub_mode = 2'b00;
  logic pump_hi, pump_lo, pump_en, sub_hi, sub_lo, sub_en, sub_fast, locked;

  int checks = 0, fails = 0, cyc = 0;
  int d_sel = 0, t = 0, dstar = 2;
  bit osc_on = 1'b1;

  tune_pll_core u_tune_pll_core (
    .clk(clk), .rst(rst), .stop(stop), .osc_in(osc), .n_val(n_val),
    .ref_sel(ref_sel), .sub_mode(sub_mode),
    .pump_hi(pump_hi), .pump_lo(pump_lo), .pump_en(pump_en),
    .sub_hi(sub_hi), .sub_lo(sub_lo), .sub_en(sub_en), .sub_fast(sub_fast),
    .locked(locked)
  );

  always #4 clk = ~clk;

  // Oscillator: period 5 clocks, first rising edge d_sel ticks after enable.
  always @(negedge clk) begin
    if (!osc_on) begin
      t   <= 0;
      osc <= 1'b0;
    end else begin
      osc <= (t >= d_sel) && (((t - d_sel) % 5) < 2);
      t   <= t + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout at %0d cycles, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic start_run(input logic [3:0] sel, input logic [15:0] n,
                           input logic [1:0] m, input int d);
    @(posedge clk); #2;
    stop = 1'b1; osc_on = 1'b0;
    ref_sel = sel; n_val = n; sub_mode = m; d_sel = d;
    wait_cyc(4);
    stop = 1'b0; osc_on = 1'b1;
  endtask

  task automatic watch(input int k, output int hi_n, output int lo_n, output int en_n,
                       output int sub_n, output int mis_n, output int fast_n,
                       output int lk_n);
    hi_n = 0; lo_n = 0; en_n = 0; sub_n = 0; mis_n = 0; fast_n = 0; lk_n = 0;
    for (int i = 0; i < k; i++) begin
      wait_cyc(1);
      hi_n   += int'(pump_hi);
      lo_n   += int'(pump_lo);
      en_n   += int'(pump_en);
      sub_n  += int'(sub_en);
      fast_n += int'(sub_fast);
      lk_n   += int'(locked);
      if (sub_hi !== pump_hi || sub_lo !== pump_lo || sub_en !== pump_en) mis_n++;
    end
  endtask

  task automatic t_reset();
    int h, l, e, s, m, f, k;
    d_sel = 0;
    watch(20, h, l, e, s, m, f, k);
    chk("R6", "pump active cycles during reset", e, 0);
    chk("R6", "locked cycles during reset", k, 0);
    chk("R6", "sub active cycles during reset", s, 0);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    int h, l, e, s, m, f, k, zeros;
    zeros = 0;
    for (int d = 0; d < 45; d++) begin
      start_run(4'd11, 16'd9, 2'b00, d);
      watch(400, h, l, e, s, m, f, k);
      if (e == 0) begin
        zeros++;
        dstar = d;
      end
    end
    chk("R4", "phases giving no drive at matched ratio", zeros, 1);
  endtask

  task automatic t_direction();
    int h, l, e, s, m, f, k;
    start_run(4'd11, 16'd4, 2'b00, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R3", "fast divider raises pump_hi", int'(h > 0), 1);
    chk("R3", "fast divider pump_lo cycles", l, 0);
    start_run(4'd11, 16'd20, 2'b00, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R3", "slow divider raises pump_lo", int'(l > 0), 1);
    chk("R3", "slow divider pump_hi cycles", h, 0);
  endtask

  task automatic t_lock();
    int h, l, e, s, m, f, k;
    start_run(4'd11, 16'd9, 2'b01, dstar + 1);
    wait_cyc(45);
    chk("R4", "one-clock lag gives pump_lo", int'(pump_lo), 1);
    chk("R11", "unlocked mode 01 copies pump_lo", int'(sub_lo), 1);
    wait_cyc(1);
    chk("R4", "one-clock lag pulse width", int'(pump_en), 0);
    wait_cyc(133);
    chk("R8", "locked before 4th clean tick", int'(locked), 0);
    wait_cyc(1);
    chk("R8", "locked at 4th clean tick", int'(locked), 1);
    watch(300, h, l, e, s, m, f, k);
    chk("R11", "pump still pulses while locked", int'(e > 0), 1);
    chk("R11", "mode 01 sub cycles while locked", s, 0);
  endtask

  task automatic t_unlock_boundary();
    start_run(4'd11, 16'd9, 2'b00, dstar + 8);
    wait_cyc(400);
    chk("R7", "8-clock pulses still lock", int'(locked), 1);
    start_run(4'd11, 16'd9, 2'b00, dstar + 9);
    wait_cyc(400);
    chk("R7", "9-clock pulses never lock", int'(locked), 0);
  endtask

  task automatic t_ratio_buffer();
    int h, l, e, s, m, f, k;
    start_run(4'd11, 16'd9, 2'b00, dstar);
    wait_cyc(450);
    chk("R8", "aligned loop locked", int'(locked), 1);
    n_val = 16'd10;
    watch(89, h, l, e, s, m, f, k);
    chk("R9", "no drive before new ratio takes effect", e, 0);
    wait_cyc(1);
    chk("R9", "lag pulse one period after reload", int'(pump_lo), 1);
    chk("R7", "locked kept on short lag", int'(locked), 1);
    wait_cyc(100);
    chk("R7", "locked drops after wide pulse", int'(locked), 0);
  endtask

  task automatic t_select();
    int h, l, e, s, m, f, k;
    start_run(4'd10, 16'd18, 2'b00, dstar);
    watch(400, h, l, e, s, m, f, k);
    chk("R1", "code 10 (90 clocks) matches N=18", e, 0);
    chk("R1", "code 10 lock", int'(locked), 1);
    start_run(4'd9, 16'd30, 2'b00, dstar);
    watch(700, h, l, e, s, m, f, k);
    chk("R1", "code 9 (150 clocks) matches N=30", e, 0);
    chk("R1", "code 9 lock", int'(locked), 1);
    start_run(4'd15, 16'd9, 2'b00, dstar);
    watch(300, h, l, e, s, m, f, k);
    chk("R1", "code 15 acts as code 11", e, 0);
    start_run(4'd12, 16'd9, 2'b00, dstar);
    watch(300, h, l, e, s, m, f, k);
    chk("R1", "code 12 acts as code 11", e, 0);
    start_run(4'd10, 16'd9, 2'b00, dstar);
    watch(300, h, l, e, s, m, f, k);
    chk("R1", "code 10 with N=9 drives high", int'(h > 0), 1);
    start_run(4'd0, 16'd900, 2'b00, dstar);
    watch(13600, h, l, e, s, m, f, k);
    chk("R1", "code 0 (4500 clocks) matches N=900", e, 0);
  endtask

  task automatic t_nzero();
    int h1, h0, l, e, s, m, f, k;
    start_run(4'd11, 16'd1, 2'b00, 0);
    watch(300, h1, l, e, s, m, f, k);
    start_run(4'd11, 16'd0, 2'b00, 0);
    watch(300, h0, l, e, s, m, f, k);
    chk("R2", "N=1 drives high", int'(h1 > 0), 1);
    chk("R2", "N=0 pump_hi cycles equal N=1", h0, h1);
  endtask

  task automatic t_stop();
    int h, l, e, s, m, f, k;
    start_run(4'd11, 16'd4, 2'b11, 0);
    for (int i = 0; i < 100 && !pump_en; i++) wait_cyc(1);
    chk("R5", "pump active before stop", int'(pump_en), 1);
    stop = 1'b1;
    wait_cyc(1);
    chk("R5", "outputs after stop",
        int'({pump_en, pump_hi, pump_lo, sub_en, locked}), 0);
    watch(100, h, l, e, s, m, f, k);
    chk("R5", "pump cycles while stopped", e + s + k, 0);
    stop = 1'b0;
  endtask

  task automatic t_sub();
    int h, l, e, s, m, f, k;
    start_run(4'd11, 16'd4, 2'b11, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R10", "mode 11 sub differs from main", m, 0);
    chk("R10", "mode 11 sub active", int'(s > 0), 1);
    start_run(4'd11, 16'd4, 2'b00, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R10", "mode 00 sub cycles", s, 0);
    chk("R10", "mode 00 main still pulses", int'(e > 0), 1);
    start_run(4'd11, 16'd4, 2'b01, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R11", "mode 01 unlocked sub differs from main", m, 0);
    chk("R11", "mode 01 sub_fast cycles", f, 0);
    start_run(4'd11, 16'd4, 2'b10, 0);
    watch(400, h, l, e, s, m, f, k);
    chk("R11", "mode 10 unlocked sub differs from main", m, 0);
    chk("R11", "mode 10 sub_fast cycles", f, 400);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_direction();
    t_lock();
    t_unlock_boundary();
    t_ratio_buffer();
    t_select();
    t_nzero();
    t_stop();
    t_sub();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule